// File: doc/BRIEF.md
# Command-Driven Boot Sequencer

This block is a hardware state machine that brings up an instrument processor board. On leaving reset it runs a march over the working RAM and then sums the default image held in non-volatile memory. It reports the outcome as a typed event and always proceeds to a command-wait state, whether or not either check found a fault.

In the wait state it accepts three commands. The first copies a chosen non-volatile image into program RAM. The second writes one word into program RAM. The third starts the application. Any other command is rejected with a reason code. Every copy and every upload is checked again by checksum before a start is allowed.

A start that is accepted raises a held start output carrying the application entry address. All memory traffic goes through one generic request port that reaches both program RAM and non-volatile memory. This port has a fixed read latency of one cycle.

Top module: `boot_seq_top`

## Requirements
- R1: After reset, every RAM word from 0 to RAM_WORDS-1 is written with the walking pattern `1 << (addr mod 32)` and read back, then written with the complement of that pattern and read back. The first address that mismatches is reported in bits [13:0] of the self-test event parameter, and bit 14 is set.
- R2: After the RAM test, image 0 (NVM words 0..IMG_WORDS-1) is checked. The checksum is the 16-bit sum of `w[31:16]+w[15:0]` over all words except the last. It must equal bits [15:0] of the last word. A mismatch sets bit 15 of the self-test parameter.
- R3: When either check fails, the self-test emits event type 5, subtype 4 with the flag parameter. When both pass, it emits type 5, subtype 1, parameter 0. In both cases the sequencer then raises `cmd_ready_o`.
- R4: The accepted commands are all type 6: subtype 1 is boot from NVM, subtype 2 is memory load, and subtype 3 is start. Any other type/subtype pair is rejected with event type 1, subtype 2, parameter 1.
- R5: A boot command whose image ID (`cmd_arg_i`) is NUM_IMG or larger is rejected with type 1, subtype 2, parameter 3, and nothing is copied.
- R6: A boot command copies NVM words `id*IMG_WORDS + k` to RAM word k for every k. It then re-sums the RAM image and reports either type 5, subtype 1, parameter 1, or type 5, subtype 4, parameter 0x00F1.
- R7: A load command writes `cmd_data_i` to RAM at `cmd_arg_i[ADDR_W-1:0]`, reads the word back and compares the folded checksums. A match reports type 5, subtype 1, parameter 2. A mismatch reports type 5, subtype 4, parameter 0x00F2.
- R8: A load with `cmd_arg_i[15]` set marks the end of an upload. If its own readback passes, the RAM image is re-summed and the result is reported as either type 5, subtype 1, parameter 4, or type 5, subtype 4, parameter 0x00F3.
- R9: A start is accepted only while a verified image exists. Otherwise it is rejected with type 1, subtype 2, parameter 2, and the sequencer stays waiting. Any boot or load command clears the verified status.
- R10: An accepted start emits type 5, subtype 1, parameter 3. From the same cycle onward, `start_o` stays high, `entry_o` holds ENTRY_ADDR, and `cmd_ready_o` stays low.
- R11: The memory port never writes with `mem_sel_o`=1 (NVM). `mem_sel_o`=0 selects program RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Sequencer is waiting for a command |
| cmd_type_i | input | 8 | Command type |
| cmd_subtype_i | input | 8 | Command subtype |
| cmd_arg_i | input | 16 | Image ID, or load address with the last flag in bit 15 |
| cmd_data_i | input | 32 | Load data word |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable |
| mem_sel_o | output | 1 | 0 = program RAM, 1 = NVM |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, one cycle after the request |
| evt_valid_o | output | 1 | Event strobe, one cycle |
| evt_type_o | output | 8 | Event type |
| evt_subtype_o | output | 8 | Event subtype |
| evt_param_o | output | 16 | Event parameter |
| start_o | output | 1 | Application start, held |
| entry_o | output | ADDR_W | Application entry address |

## Verification
Some properties are checked on every cycle. NVM is never written. Events are single-cycle strobes. Rejections always carry subtype 2 and a known reason code. Once start rises it is sticky, it coincides with the start event, it carries the entry address, and it locks out further commands. Other behaviour can only be shown by the bench's scenarios, which compare every event against an independent model of memory contents. These scenarios cover the first-failing RAM address, the image checksum arithmetic, the copy source offsets, readback failures caused by a stuck bit, good and bad uploads, and the rule that a start needs a freshly verified image.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned CW = 16;

  localparam logic [7:0] EVT_T_PROG  = 8'd5;
  localparam logic [7:0] EVT_S_OK    = 8'd1;
  localparam logic [7:0] EVT_S_ERR   = 8'd4;
  localparam logic [7:0] EVT_T_ACC   = 8'd1;
  localparam logic [7:0] EVT_S_REJ   = 8'd2;
  localparam logic [7:0] CMD_T_BOOT  = 8'd6;
  localparam logic [7:0] CMD_S_NVM   = 8'd1;
  localparam logic [7:0] CMD_S_LOAD  = 8'd2;
  localparam logic [7:0] CMD_S_START = 8'd3;

  localparam logic [CW-1:0] P_SELFTEST   = 16'h0000;
  localparam logic [CW-1:0] P_COPY_OK    = 16'h0001;
  localparam logic [CW-1:0] P_LOAD_OK    = 16'h0002;
  localparam logic [CW-1:0] P_START      = 16'h0003;
  localparam logic [CW-1:0] P_UPLOAD_OK  = 16'h0004;
  localparam logic [CW-1:0] P_COPY_BAD   = 16'h00F1;
  localparam logic [CW-1:0] P_LOAD_BAD   = 16'h00F2;
  localparam logic [CW-1:0] P_UPLOAD_BAD = 16'h00F3;
  localparam logic [CW-1:0] REJ_CODE     = 16'h0001;
  localparam logic [CW-1:0] REJ_NOIMG    = 16'h0002;
  localparam logic [CW-1:0] REJ_IMGID    = 16'h0003;

  typedef enum logic [1:0] {K_BOOT, K_LOAD, K_START, K_BAD} cmd_kind_e;

  typedef enum logic [3:0] {
    S_T_WR, S_T_RD, S_T_CK, S_N_RD, S_N_CK, S_REPORT, S_IDLE,
    S_C_RD, S_C_WR, S_L_WR, S_L_RD, S_L_CK, S_V_RD, S_V_CK, S_RUN
  } seq_state_e;

  function automatic logic [CW-1:0] fold_word(input logic [DW-1:0] w);
    return w[31:16] + w[15:0];
  endfunction

  function automatic logic [DW-1:0] walk_pat(input logic [4:0] pos);
    return DW'(1) << pos;
  endfunction
endpackage

// File: rtl/boot_cks_acc.sv
module boot_cks_acc
  import boot_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] word_i,
  output logic [CW-1:0] sum_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_o <= '0;
    else if (clr_i) sum_o <= '0;
    else if (add_i) sum_o <= sum_o + fold_word(word_i);
  end
endmodule

// File: rtl/boot_cmd_dec.sv
module boot_cmd_dec
  import boot_seq_pkg::*;
(
  input  logic [7:0] type_i,
  input  logic [7:0] subtype_i,
  output cmd_kind_e  kind_o
);
  always_comb begin
    kind_o = K_BAD;
    if (type_i == CMD_T_BOOT) begin
      unique case (subtype_i)
        CMD_S_NVM:   kind_o = K_BOOT;
        CMD_S_LOAD:  kind_o = K_LOAD;
        CMD_S_START: kind_o = K_START;
        default:     kind_o = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/boot_evt_reg.sv
module boot_evt_reg
  import boot_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [7:0]    type_i,
  input  logic [7:0]    sub_i,
  input  logic [CW-1:0] param_i,
  output logic          valid_o,
  output logic [7:0]    type_o,
  output logic [7:0]    sub_o,
  output logic [CW-1:0] param_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      type_o  <= '0;
      sub_o   <= '0;
      param_o <= '0;
    end else begin
      valid_o <= fire_i;
      if (fire_i) begin
        type_o  <= type_i;
        sub_o   <= sub_i;
        param_o <= param_i;
      end
    end
  end
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned RAM_WORDS = 16,
  parameter int unsigned IMG_WORDS = 8,
  parameter int unsigned NUM_IMG   = 2,
  parameter logic [ADDR_W-1:0] ENTRY_ADDR = 8'd4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [7:0]        cmd_type_i,
  input  logic [7:0]        cmd_subtype_i,
  input  logic [15:0]       cmd_arg_i,
  input  logic [31:0]       cmd_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_sel_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  output logic              evt_valid_o,
  output logic [7:0]        evt_type_o,
  output logic [7:0]        evt_subtype_o,
  output logic [15:0]       evt_param_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] entry_o
);
  localparam logic [ADDR_W-1:0] RAM_LAST = ADDR_W'(RAM_WORDS - 1);
  localparam logic [ADDR_W-1:0] IMG_LAST = ADDR_W'(IMG_WORDS - 1);
  localparam logic [ADDR_W-1:0] IMG_SIZE = ADDR_W'(IMG_WORDS);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] idx_q, img_base_q, ld_addr_q, fail_addr_q;
  logic [DW-1:0]     ld_data_q;
  logic              phase_q, ram_bad_q, nvm_bad_q, ld_last_q, vsrc_load_q, image_ok_q;

  cmd_kind_e     kind;
  logic          acc_clr, acc_add;
  logic [CW-1:0] acc_sum;
  logic          fire;
  logic [7:0]    fire_type, fire_sub;
  logic [CW-1:0] fire_param;
  logic [DW-1:0] test_pat;
  logic          img_last, img_match, ld_match, id_bad;

  boot_cmd_dec u_dec (.type_i(cmd_type_i), .subtype_i(cmd_subtype_i), .kind_o(kind));

  boot_cks_acc u_acc (
    .clk_i, .rst_ni, .clr_i(acc_clr), .add_i(acc_add),
    .word_i(mem_rdata_i), .sum_o(acc_sum)
  );

  boot_evt_reg u_evt (
    .clk_i, .rst_ni, .fire_i(fire), .type_i(fire_type), .sub_i(fire_sub),
    .param_i(fire_param), .valid_o(evt_valid_o), .type_o(evt_type_o),
    .sub_o(evt_subtype_o), .param_o(evt_param_o)
  );

  assign test_pat    = phase_q ? ~walk_pat(idx_q[4:0]) : walk_pat(idx_q[4:0]);
  assign img_last    = (idx_q == IMG_LAST);
  assign img_match   = (acc_sum == mem_rdata_i[15:0]);
  assign ld_match    = (fold_word(mem_rdata_i) == fold_word(ld_data_q));
  assign id_bad      = (cmd_arg_i >= 16'(NUM_IMG));
  assign cmd_ready_o = (state_q == S_IDLE);
  assign start_o     = (state_q == S_RUN);
  assign entry_o     = ENTRY_ADDR;

  // memory port
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_sel_o   = 1'b0;
    mem_addr_o  = idx_q;
    mem_wdata_o = '0;
    unique case (state_q)
      S_T_WR: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = test_pat; end
      S_T_RD, S_V_RD: mem_req_o = 1'b1;
      S_N_RD: begin mem_req_o = 1'b1; mem_sel_o = 1'b1; end
      S_C_RD: begin mem_req_o = 1'b1; mem_sel_o = 1'b1; mem_addr_o = img_base_q + idx_q; end
      S_C_WR: begin mem_req_o = 1'b1; mem_we_o = 1'b1; mem_wdata_o = mem_rdata_i; end
      S_L_WR: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = ld_addr_q; mem_wdata_o = ld_data_q;
      end
      S_L_RD: begin mem_req_o = 1'b1; mem_addr_o = ld_addr_q; end
      default: ;
    endcase
  end

  // checksum accumulator control
  always_comb begin
    acc_add = ((state_q == S_N_CK) || (state_q == S_V_CK)) && !img_last;
    acc_clr = ((state_q == S_T_CK) && phase_q && (idx_q == RAM_LAST)) ||
              ((state_q == S_C_WR) && img_last) ||
              ((state_q == S_L_CK) && ld_match && ld_last_q);
  end

  // event generation
  always_comb begin
    fire       = 1'b0;
    fire_type  = EVT_T_PROG;
    fire_sub   = EVT_S_OK;
    fire_param = '0;
    unique case (state_q)
      S_REPORT: begin
        fire = 1'b1;
        if (ram_bad_q || nvm_bad_q) begin
          fire_sub   = EVT_S_ERR;
          fire_param = {nvm_bad_q, ram_bad_q, 14'(fail_addr_q)};
        end else fire_param = P_SELFTEST;
      end
      S_IDLE: if (cmd_valid_i) begin
        fire_type = EVT_T_ACC;
        fire_sub  = EVT_S_REJ;
        unique case (kind)
          K_BOOT:  begin fire = id_bad; fire_param = REJ_IMGID; end
          K_LOAD:  fire = 1'b0;
          K_START: begin
            fire = 1'b1;
            if (image_ok_q) begin
              fire_type = EVT_T_PROG; fire_sub = EVT_S_OK; fire_param = P_START;
            end else fire_param = REJ_NOIMG;
          end
          default: begin fire = 1'b1; fire_param = REJ_CODE; end
        endcase
      end
      S_L_CK: begin
        if (!ld_match) begin
          fire = 1'b1; fire_sub = EVT_S_ERR; fire_param = P_LOAD_BAD;
        end else if (!ld_last_q) begin
          fire = 1'b1; fire_param = P_LOAD_OK;
        end
      end
      S_V_CK: if (img_last) begin
        fire = 1'b1;
        if (img_match) fire_param = vsrc_load_q ? P_UPLOAD_OK : P_COPY_OK;
        else begin
          fire_sub   = EVT_S_ERR;
          fire_param = vsrc_load_q ? P_UPLOAD_BAD : P_COPY_BAD;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_T_WR;
      idx_q       <= '0;
      phase_q     <= 1'b0;
      ram_bad_q   <= 1'b0;
      nvm_bad_q   <= 1'b0;
      fail_addr_q <= '0;
      img_base_q  <= '0;
      ld_addr_q   <= '0;
      ld_data_q   <= '0;
      ld_last_q   <= 1'b0;
      vsrc_load_q <= 1'b0;
      image_ok_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_T_WR: state_q <= S_T_RD;
        S_T_RD: state_q <= S_T_CK;
        S_T_CK: begin
          if (mem_rdata_i != test_pat && !ram_bad_q) begin
            ram_bad_q   <= 1'b1;
            fail_addr_q <= idx_q;
          end
          phase_q <= ~phase_q;
          if (!phase_q) state_q <= S_T_WR;
          else if (idx_q == RAM_LAST) begin idx_q <= '0; state_q <= S_N_RD; end
          else begin idx_q <= idx_q + 1'b1; state_q <= S_T_WR; end
        end
        S_N_RD: state_q <= S_N_CK;
        S_N_CK: begin
          if (img_last) begin
            nvm_bad_q <= !img_match;
            idx_q     <= '0;
            state_q   <= S_REPORT;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_N_RD;
          end
        end
        S_REPORT: state_q <= S_IDLE;
        S_IDLE: if (cmd_valid_i) begin
          unique case (kind)
            K_BOOT: if (!id_bad) begin
              img_base_q  <= ADDR_W'(cmd_arg_i) * IMG_SIZE;
              idx_q       <= '0;
              image_ok_q  <= 1'b0;
              vsrc_load_q <= 1'b0;
              state_q     <= S_C_RD;
            end
            K_LOAD: begin
              ld_addr_q   <= ADDR_W'(cmd_arg_i[14:0]);
              ld_last_q   <= cmd_arg_i[15];
              ld_data_q   <= cmd_data_i;
              image_ok_q  <= 1'b0;
              vsrc_load_q <= 1'b1;
              state_q     <= S_L_WR;
            end
            K_START: if (image_ok_q) state_q <= S_RUN;
            default: ;
          endcase
        end
        S_C_RD: state_q <= S_C_WR;
        S_C_WR: begin
          if (img_last) begin idx_q <= '0; state_q <= S_V_RD; end
          else begin idx_q <= idx_q + 1'b1; state_q <= S_C_RD; end
        end
        S_L_WR: state_q <= S_L_RD;
        S_L_RD: state_q <= S_L_CK;
        S_L_CK: begin
          if (ld_match && ld_last_q) begin idx_q <= '0; state_q <= S_V_RD; end
          else state_q <= S_IDLE;
        end
        S_V_RD: state_q <= S_V_CK;
        S_V_CK: begin
          if (img_last) begin
            image_ok_q <= img_match;
            idx_q      <= '0;
            state_q    <= S_IDLE;
          end else begin
            idx_q   <= idx_q + 1'b1;
            state_q <= S_V_RD;
          end
        end
        S_RUN: state_q <= S_RUN;
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ENTRY_ADDR = 8'd4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_ready_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_sel_o,
  input logic              evt_valid_o,
  input logic [7:0]        evt_type_o,
  input logic [7:0]        evt_subtype_o,
  input logic [15:0]       evt_param_o,
  input logic              start_o,
  input logic [ADDR_W-1:0] entry_o
);
  a_r11_nvm_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !mem_sel_o);
  a_r11_we_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o);
  a_r3_evt_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |=> !evt_valid_o);
  a_r4_reject_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_type_o == 8'd1) |->
      (evt_subtype_o == 8'd2 && evt_param_o >= 16'd1 && evt_param_o <= 16'd3));
  a_r10_start_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> start_o);
  a_r10_entry_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> entry_o == ENTRY_ADDR);
  a_r10_no_cmd_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !cmd_ready_o);
  a_r10_start_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> (evt_valid_o && evt_type_o == 8'd5 &&
                        evt_subtype_o == 8'd1 && evt_param_o == 16'd3));
endmodule

bind boot_seq_top boot_seq_chk #(.ADDR_W(ADDR_W), .ENTRY_ADDR(ENTRY_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_ready_o(cmd_ready_o), .mem_req_o(mem_req_o),
  .mem_we_o(mem_we_o), .mem_sel_o(mem_sel_o), .evt_valid_o(evt_valid_o),
  .evt_type_o(evt_type_o), .evt_subtype_o(evt_subtype_o), .evt_param_o(evt_param_o),
  .start_o(start_o), .entry_o(entry_o)
);

// File: tb/boot_seq_top_tb_top.sv
`timescale 1ns/1ps
module boot_seq_top_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_type = '0, cmd_sub = '0;
  logic [15:0] cmd_arg = '0;
  logic [31:0] cmd_data = '0;
  logic        cmd_ready_o, mem_req_o, mem_we_o, mem_sel_o;
  logic [7:0]  mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] mem_rdata = '0;
  logic        evt_valid_o, start_o;
  logic [7:0]  evt_type_o, evt_subtype_o, entry_o;
  logic [15:0] evt_param_o;

  boot_seq_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready_o),
    .cmd_type_i(cmd_type), .cmd_subtype_i(cmd_sub), .cmd_arg_i(cmd_arg),
    .cmd_data_i(cmd_data), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_sel_o(mem_sel_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata), .evt_valid_o(evt_valid_o), .evt_type_o(evt_type_o),
    .evt_subtype_o(evt_subtype_o), .evt_param_o(evt_param_o), .start_o(start_o),
    .entry_o(entry_o)
  );

  // behavioural memories
  logic [31:0] ram [0:255];
  logic [31:0] nvm [0:255];
  logic        stuck_en = 1'b0;
  logic [7:0]  stuck_addr = '0;
  logic [31:0] stuck_mask = '0;

  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o && !mem_sel_o) ram[mem_addr_o] <= mem_wdata_o;
      else if (!mem_we_o)
        mem_rdata <= mem_sel_o ? nvm[mem_addr_o] :
                     (ram[mem_addr_o] | ((stuck_en && mem_addr_o == stuck_addr) ? stuck_mask : 32'h0));
    end
  end

  int tests = 0, fails = 0;
  bit done = 0;
  bit run_exp = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] f16(input logic [31:0] w);
    return w[31:16] + w[15:0];
  endfunction

  function automatic logic [15:0] nvm_sum(input int base);
    logic [15:0] s = '0;
    for (int k = 0; k < 7; k++) s += f16(nvm[base+k]);
    return s;
  endfunction

  function automatic logic [15:0] ram_sum();
    logic [15:0] s = '0;
    for (int k = 0; k < 7; k++) s += f16(ram[k]);
    return s;
  endfunction

  task automatic expect_evt(input string tag, input logic [7:0] t, input logic [7:0] s, input logic [15:0] p);
    exp_q.push_back({t, s, p});
    tag_q.push_back(tag);
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_ni) begin
      if (evt_valid_o) begin
        if (exp_q.size() == 0)
          chk("EVT-unexpected", 1'b0, {evt_type_o, evt_subtype_o, evt_param_o}, 32'h0);
        else begin
          logic [31:0] e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          chk(tg, {evt_type_o, evt_subtype_o, evt_param_o} == e,
              {evt_type_o, evt_subtype_o, evt_param_o}, e);
          if (e == 32'h0501_0003) run_exp = 1;
        end
      end
      chk("R10 start level", start_o == run_exp, {31'h0, start_o}, {31'h0, run_exp});
    end
  end

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic wait_idle();
    wait_drain();
    while (!cmd_ready_o) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] t, input logic [7:0] s, input logic [15:0] a, input logic [31:0] d);
    cmd_type = t; cmd_sub = s; cmd_arg = a; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  logic [31:0] up [0:7];

  initial begin
    for (int i = 0; i < 256; i++) begin ram[i] = '0; nvm[i] = '0; end
    for (int k = 0; k < 7; k++) begin
      nvm[k]     = 32'hA500_1200 + k * 32'h0101_0101;
      nvm[8 + k] = 32'h0F0F_3300 ^ (k * 32'h0011_0203);
    end
    nvm[7]  = {16'h0, nvm_sum(0) + 16'd1};   // image 0 corrupted for first boot
    nvm[15] = {16'h0, nvm_sum(8) + 16'd5};   // image 1 always corrupted
    stuck_en = 1'b1; stuck_addr = 8'd5; stuck_mask = 32'h8;

    repeat (3) @(negedge clk);
    chk("R3 reset evt", !evt_valid_o, {31'h0, evt_valid_o}, 32'h0);
    chk("R10 reset start", !start_o, {31'h0, start_o}, 32'h0);
    chk("R3 reset ready", !cmd_ready_o, {31'h0, cmd_ready_o}, 32'h0);

    // R1/R2: RAM fault at word 5 and bad image 0, flow still continues
    expect_evt("R1 R2 selftest error", 8'd5, 8'd4, 16'hC005);
    rst_ni = 1'b1;
    wait_idle();
    chk("R3 waits after error", cmd_ready_o, {31'h0, cmd_ready_o}, 32'h1);

    rst_ni = 1'b0; stuck_en = 1'b0; nvm[7] = {16'h0, nvm_sum(0)};
    @(negedge clk);
    expect_evt("R3 selftest ok", 8'd5, 8'd1, 16'h0000);
    rst_ni = 1'b1;
    wait_idle();

    expect_evt("R9 start without image", 8'd1, 8'd2, 16'h0002);
    send(8'd6, 8'd3, 16'h0, 32'h0); wait_idle();
    expect_evt("R4 bad type", 8'd1, 8'd2, 16'h0001);
    send(8'd9, 8'd1, 16'h0, 32'h0); wait_idle();
    expect_evt("R4 bad subtype", 8'd1, 8'd2, 16'h0001);
    send(8'd6, 8'd7, 16'h0, 32'h0); wait_idle();
    expect_evt("R5 image id range", 8'd1, 8'd2, 16'h0003);
    send(8'd6, 8'd1, 16'd2, 32'h0); wait_idle();

    expect_evt("R6 copy bad image", 8'd5, 8'd4, 16'h00F1);
    send(8'd6, 8'd1, 16'd1, 32'h0); wait_idle();
    for (int k = 0; k < 8; k++)
      chk("R6 copy contents", ram[k] == nvm[8 + k], ram[k], nvm[8 + k]);
    expect_evt("R9 start after bad copy", 8'd1, 8'd2, 16'h0002);
    send(8'd6, 8'd3, 16'h0, 32'h0); wait_idle();

    stuck_en = 1'b1; stuck_addr = 8'd3; stuck_mask = 32'h1;
    expect_evt("R7 load readback bad", 8'd5, 8'd4, 16'h00F2);
    send(8'd6, 8'd2, 16'd3, 32'h1234_0000); wait_idle();
    stuck_en = 1'b0;
    chk("R7 load written", ram[3] == 32'h1234_0000, ram[3], 32'h1234_0000);

    expect_evt("R8 upload bad sum", 8'd5, 8'd4, 16'h00F3);
    send(8'd6, 8'd2, 16'h8007, {16'h0, ram_sum() + 16'd1}); wait_idle();
    expect_evt("R9 start after bad upload", 8'd1, 8'd2, 16'h0002);
    send(8'd6, 8'd3, 16'h0, 32'h0); wait_idle();

    for (int k = 0; k < 7; k++) up[k] = 32'h1000_0000 + k * 32'h0003_0007;
    up[7] = '0;
    for (int k = 0; k < 7; k++) up[7][15:0] += f16(up[k]);
    for (int k = 0; k < 7; k++) begin
      expect_evt("R7 load ok", 8'd5, 8'd1, 16'h0002);
      send(8'd6, 8'd2, 16'(k), up[k]); wait_idle();
    end
    expect_evt("R8 upload verified", 8'd5, 8'd1, 16'h0004);
    send(8'd6, 8'd2, 16'h8007, up[7]); wait_idle();
    for (int k = 0; k < 8; k++)
      chk("R7 upload contents", ram[k] == up[k], ram[k], up[k]);

    expect_evt("R6 copy good image", 8'd5, 8'd1, 16'h0001);
    send(8'd6, 8'd1, 16'd0, 32'h0); wait_idle();
    for (int k = 0; k < 8; k++)
      chk("R6 copy image0", ram[k] == nvm[k], ram[k], nvm[k]);

    expect_evt("R10 start accepted", 8'd5, 8'd1, 16'h0003);
    send(8'd6, 8'd3, 16'h0, 32'h0);
    wait_drain();
    chk("R10 entry", entry_o == 8'd4, {24'h0, entry_o}, 32'd4);
    chk("R10 start high", start_o, {31'h0, start_o}, 32'h1);
    // R11/R10: further commands are ignored and RAM is untouched
    cmd_type = 8'd6; cmd_sub = 8'd1; cmd_arg = 16'd1; cmd_valid = 1'b1;
    repeat (20) @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 ready stays low", !cmd_ready_o, {31'h0, cmd_ready_o}, 32'h0);
    chk("R11 ram unchanged", ram[0] == nvm[0], ram[0], nvm[0]);
    chk("R10 no leftover events", exp_q.size() == 0, exp_q.size(), 32'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule